// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a bank of 32-bit shadow registers that mirror a one-time-programmable fuse array, so that bus masters read fuse contents without waiting for a fuse access. Software reads and writes the shadow words through a simple single-cycle request port. A one-cycle reload request walks the fuse array word by word, from the lowest index upward, and copies each fuse word into its shadow. While the walk runs the block reports itself busy.

Per-word read-lock and write-lock inputs guard the bank. Any access that breaks a lock rule, and any write attempted while a reload runs, raises one sticky error flag. While that flag is up, every further read, write or reload request is refused until a dedicated clear pulse drops it. The fuse array here is a behavioural model: each word holds a computed pattern and answers a read after a fixed number of cycles.

Top module: `fuse_shadow_bank`

## Requirements
- R1: Shadow word n answers at byte address 0x400 + 16·n (low four offset bits zero); NWORDS defaults to 128. Every read request gets `bus_rvalid` high in the following cycle with the result on `bus_rdata`.
- R2: A `reload_set` pulse while idle and error-free raises `busy` in the next cycle; `busy` then stays high for exactly NWORDS·(FUSE_LAT+1) cycles and clears by itself. Afterwards shadow word n reads as fuse word n, which holds (n·0x9E3779B1 mod 2^32) XOR 0x13572468.
- R3: A write to a shadow word while `busy` is high sets `error` and leaves that word unchanged.
- R4: A write to a word whose `wr_lock` bit is set sets `error` and leaves the word unchanged.
- R5: A read of a word whose `rd_lock` bit is set returns 0xBADABADA and sets `error`.
- R6: `error` stays set until an `err_clr` pulse; while it is set, reads return zero, writes leave the bank unchanged and `reload_set` starts no reload.
- R7: A reload copies words in ascending index order, one fuse read of FUSE_LAT cycles plus one issue cycle per word, so word k is updated FUSE_LAT+1 cycles after word k-1.
- R8: A read of an address below the window, not aligned to 16 bytes, or at or beyond word NWORDS returns zero without setting `error`; a write there changes nothing and sets no error.
- R9: After reset `busy` and `error` are low and every shadow word reads zero until the first reload completes.
- R10: An unlocked write while idle and error-free stores the data, and the next read of that word returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read result valid, one cycle after a read request |
| bus_rdata | output | 32 | Read result |
| reload_set | input | 1 | Pulse requesting a full reload from the fuses |
| err_clr | input | 1 | Pulse clearing the sticky error flag |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |
| busy | output | 1 | Reload in progress |
| error | output | 1 | Sticky access-violation flag |

## Verification
The bench samples the bank part way through a reload to prove the copy order: a low word must already hold its fuse value while a high word still holds zero, which a design walking downward or copying all at once would fail. It times the busy window to the cycle, catching a sequencer that drops the issue cycle or stops one word short. It writes during a reload and then reads the word before the walk reaches it, so a design that lets the write through shows the written value instead of the older fuse value. It also confirms that a refused read returns zero rather than shadow data, that a reload request is ignored while the error flag is up, and that misaligned and out-of-range addresses neither alias onto real words nor raise the flag.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    RESP_ZERO,
    RESP_POISON,
    RESP_DATA
  } resp_kind_e;

  // Contents of the behavioural fuse array, word by word.
  function automatic logic [31:0] fuse_pattern(input logic [31:0] idx);
    logic [31:0] mixed;
    mixed = idx * 32'h9E37_79B1;
    return mixed ^ 32'h1357_2468;
  endfunction

endpackage

// File: rtl/fsb_addr_dec.sv
module fsb_addr_dec #(
  parameter int NWORDS      = 128,
  parameter int ADDR_W      = 12,
  parameter int SHADOW_BASE = 'h400,
  parameter int STRIDE_LOG2 = 4,
  parameter int IDX_W       = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SHADOW_BASE);
  localparam logic [ADDR_W-1:0] NW_A   = ADDR_W'(NWORDS);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] word;
  logic              above;
  logic              aligned;

  always_comb begin
    offset  = addr - BASE_A;
    above   = addr >= BASE_A;
    aligned = offset[STRIDE_LOG2-1:0] == '0;
    word    = offset >> STRIDE_LOG2;
    hit     = above && aligned && (word < NW_A);
    idx     = word[IDX_W-1:0];
  end
endmodule

// File: rtl/fsb_fuse_model.sv
module fsb_fuse_model #(
  parameter int NWORDS   = 128,
  parameter int IDX_W    = $clog2(NWORDS),
  parameter int FUSE_LAT = 4,
  parameter int CNT_W    = $clog2(FUSE_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);
  import fsb_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (rd_en) begin
      cnt_q <= CNT_W'(FUSE_LAT);
      idx_q <= rd_idx;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign rd_valid = cnt_q == CNT_W'(1);
  assign rd_data  = fuse_pattern(32'(idx_q));
endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
  parameter int NWORDS = 128,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fuse_valid,
  output logic             fuse_rd_en,
  output logic [IDX_W-1:0] fuse_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             busy
);
  import fsb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            ptr_q   <= '0;
            state_q <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (fuse_valid) begin
            if (ptr_q == LAST_IDX) begin
              state_q <= SEQ_IDLE;
            end else begin
              ptr_q   <= ptr_q + IDX_W'(1);
              state_q <= SEQ_ISSUE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    fuse_rd_en = state_q == SEQ_ISSUE;
    fuse_idx   = ptr_q;
    wr_en      = (state_q == SEQ_WAIT) && fuse_valid;
    wr_idx     = ptr_q;
    busy       = state_q != SEQ_IDLE;
  end
endmodule

// File: rtl/fsb_access_ctl.sv
module fsb_access_ctl (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic                     hit,
  input  logic                     busy,
  input  logic                     rd_locked,
  input  logic                     wr_locked,
  input  logic                     reload_set,
  input  logic                     err_clr,
  output logic                     shadow_we,
  output logic                     reload_go,
  output logic                     violation,
  output fsb_pkg::resp_kind_e      resp_kind,
  output logic                     error
);
  import fsb_pkg::*;

  logic error_q;
  logic accept;
  logic rd_go;
  logic wr_go;
  logic rd_bad;
  logic wr_bad;

  always_comb begin
    accept    = req && !error_q;
    rd_go     = accept && !we;
    wr_go     = accept && we && hit;
    rd_bad    = rd_go && hit && rd_locked;
    wr_bad    = wr_go && (busy || wr_locked);
    shadow_we = wr_go && !busy && !wr_locked;
    reload_go = reload_set && !error_q && !busy;
    violation = rd_bad || wr_bad;
    if (!rd_go || !hit) begin
      resp_kind = RESP_ZERO;
    end else if (rd_locked) begin
      resp_kind = RESP_POISON;
    end else begin
      resp_kind = RESP_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error_q <= 1'b0;
    end else begin
      error_q <= (error_q && !err_clr) || violation;
    end
  end

  assign error = error_q;
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int NWORDS      = 128,
  parameter int ADDR_W      = 12,
  parameter int SHADOW_BASE = 'h400,
  parameter int STRIDE_LOG2 = 4,
  parameter int FUSE_LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic              reload_set,
  input  logic              err_clr,
  input  logic [NWORDS-1:0] rd_lock,
  input  logic [NWORDS-1:0] wr_lock,
  output logic              busy,
  output logic              error
);
  import fsb_pkg::*;

  localparam int IDX_W = $clog2(NWORDS);
  localparam int CNT_W = $clog2(FUSE_LAT + 1);

  // Named internal events, also observed by the bound checker.
  logic             bus_hit;
  logic [IDX_W-1:0] bus_idx;
  logic             shadow_we;
  logic             reload_go;
  logic             violation;
  resp_kind_e       resp_kind;
  logic             fuse_rd_en;
  logic [IDX_W-1:0] fuse_idx;
  logic             fuse_valid;
  logic [31:0]      fuse_data;
  logic             reload_wr_en;
  logic [IDX_W-1:0] reload_idx;

  logic [31:0] shadow_q [NWORDS];
  logic        rvalid_q;
  logic [31:0] rdata_q;

  fsb_addr_dec #(
    .NWORDS(NWORDS), .ADDR_W(ADDR_W), .SHADOW_BASE(SHADOW_BASE),
    .STRIDE_LOG2(STRIDE_LOG2), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .hit(bus_hit), .idx(bus_idx)
  );

  fsb_access_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .hit(bus_hit),
    .busy(busy), .rd_locked(rd_lock[bus_idx]), .wr_locked(wr_lock[bus_idx]),
    .reload_set(reload_set), .err_clr(err_clr), .shadow_we(shadow_we),
    .reload_go(reload_go), .violation(violation), .resp_kind(resp_kind),
    .error(error)
  );

  fsb_reload_seq #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(reload_go), .fuse_valid(fuse_valid),
    .fuse_rd_en(fuse_rd_en), .fuse_idx(fuse_idx), .wr_en(reload_wr_en),
    .wr_idx(reload_idx), .busy(busy)
  );

  fsb_fuse_model #(
    .NWORDS(NWORDS), .IDX_W(IDX_W), .FUSE_LAT(FUSE_LAT), .CNT_W(CNT_W)
  ) u_fuse (
    .clk(clk), .rst_n(rst_n), .rd_en(fuse_rd_en), .rd_idx(fuse_idx),
    .rd_valid(fuse_valid), .rd_data(fuse_data)
  );

  // Shadow storage: the reload port and the bus port never collide,
  // because bus writes are refused while the sequencer is busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow_q[i] <= '0;
    end else if (reload_wr_en) begin
      shadow_q[reload_idx] <= fuse_data;
    end else if (shadow_we) begin
      shadow_q[bus_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        unique case (resp_kind)
          RESP_POISON: rdata_q <= POISON_WORD;
          RESP_DATA:   rdata_q <= shadow_q[bus_idx];
          default:     rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int NWORDS = 128,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_hit,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [NWORDS-1:0] rd_lock,
  input logic [NWORDS-1:0] wr_lock,
  input logic              busy,
  input logic              error,
  input logic              err_clr,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic              shadow_we,
  input logic              reload_go,
  input logic              reload_wr_en,
  input logic [IDX_W-1:0]  reload_idx
);
  import fsb_pkg::*;

  logic [IDX_W-1:0] exp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_idx_q <= '0;
    else if (reload_go) exp_idx_q <= '0;
    else if (reload_wr_en) exp_idx_q <= exp_idx_q + IDX_W'(1);
  end

  p_busy_follows_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |=> busy);

  p_no_write_in_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_hit && busy |-> !shadow_we);

  p_err_on_reload_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_hit && busy && !error |=> error);

  p_wr_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_hit && wr_lock[bus_idx] |-> !shadow_we);

  p_rd_lock_poison_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_hit && rd_lock[bus_idx] && !error
    |=> bus_rvalid && (bus_rdata == POISON_WORD) && error);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error && !err_clr |=> error);

  p_err_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !shadow_we && !reload_go);

  p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr_en |-> reload_idx == exp_idx_q);

  p_miss_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && !bus_hit |=> bus_rvalid && (bus_rdata == 32'h0));

  p_miss_no_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_hit && !error |=> !error);
endmodule

bind fuse_shadow_bank fsb_checker #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_fsb_checker (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_hit(bus_hit), .bus_idx(bus_idx), .rd_lock(rd_lock), .wr_lock(wr_lock),
  .busy(busy), .error(error), .err_clr(err_clr), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .shadow_we(shadow_we), .reload_go(reload_go),
  .reload_wr_en(reload_wr_en), .reload_idx(reload_idx)
);

// File: tb/fuse_shadow_bank_bench.sv
module fuse_shadow_bank_bench;
  localparam int NW  = 128;
  localparam int LAT = 4;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic          reload_set = 1'b0;
  logic          err_clr = 1'b0;
  logic [NW-1:0] rd_lock = '0;
  logic [NW-1:0] wr_lock = '0;
  logic          busy;
  logic          error;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fuse_shadow_bank u_fuse_shadow_bank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .reload_set(reload_set), .err_clr(err_clr),
    .rd_lock(rd_lock), .wr_lock(wr_lock), .busy(busy), .error(error)
  );

  function automatic logic [31:0] fuse_val(input int n);
    logic [63:0] prod;
    prod = 64'(n) * 64'h0000_0000_9E37_79B1;
    return prod[31:0] ^ 32'h1357_2468;
  endfunction

  function automatic logic [AW-1:0] waddr(input int n);
    return AW'(32'h400 + n * 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse_reload();
    @(negedge clk); reload_set = 1'b1;
    @(negedge clk); reload_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R9 busy after reset", 32'(busy), 0);
    chk("R9 error after reset", 32'(error), 0);
    bus_read(waddr(0), d, v);
    chk("R9 word0 zero", d, 0);
    chk("R1 rvalid", 32'(v), 1);
    bus_read(waddr(77), d, v);
    chk("R9 word77 zero", d, 0);
  endtask

  task automatic t_order();
    logic [31:0] d; logic v;
    pulse_reload();
    chk("R2 busy rises", 32'(busy), 1);
    repeat (14) @(negedge clk);
    bus_read(waddr(1), d, v);
    chk("R7 early word copied", d, fuse_val(1));
    bus_read(waddr(120), d, v);
    chk("R7 late word not yet copied", d, 0);
    wait_idle();
  endtask

  task automatic t_reload_len();
    logic [31:0] d; logic v;
    int n;
    pulse_reload();
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk("R2 busy length", 32'(n), 32'(NW * (LAT + 1)));
    bus_read(waddr(0), d, v);
    chk("R2 word0 fuse", d, fuse_val(0));
    bus_read(waddr(64), d, v);
    chk("R2 word64 fuse", d, fuse_val(64));
    bus_read(waddr(NW - 1), d, v);
    chk("R1 R2 last word fuse", d, fuse_val(NW - 1));
  endtask

  task automatic t_write();
    logic [31:0] d; logic v;
    bus_write(waddr(10), 32'hDEAD_BEEF);
    chk("R10 no error", 32'(error), 0);
    bus_read(waddr(10), d, v);
    chk("R10 readback", d, 32'hDEAD_BEEF);
    bus_write(waddr(0) + AW'(4), 32'h1111_1111);
    chk("R8 misaligned write no error", 32'(error), 0);
    bus_read(waddr(0), d, v);
    chk("R8 misaligned write no alias", d, fuse_val(0));
  endtask

  task automatic t_wr_lock();
    logic [31:0] d; logic v;
    wr_lock[12] = 1'b1;
    bus_write(waddr(12), 32'hCAFE_0012);
    chk("R4 error set", 32'(error), 1);
    pulse_clr();
    chk("R6 clear drops error", 32'(error), 0);
    bus_read(waddr(12), d, v);
    chk("R4 word unchanged", d, fuse_val(12));
    wr_lock[12] = 1'b0;
  endtask

  task automatic t_rd_lock();
    logic [31:0] d; logic v;
    rd_lock[20] = 1'b1;
    bus_read(waddr(20), d, v);
    chk("R5 poison", d, 32'hBADA_BADA);
    chk("R5 error set", 32'(error), 1);
    bus_read(waddr(10), d, v);
    chk("R6 refused read zero", d, 0);
    bus_write(waddr(10), 32'h5555_AAAA);
    pulse_reload();
    chk("R6 reload refused", 32'(busy), 0);
    chk("R6 error sticky", 32'(error), 1);
    pulse_clr();
    bus_read(waddr(10), d, v);
    chk("R6 refused write no effect", d, 32'hDEAD_BEEF);
    rd_lock[20] = 1'b0;
  endtask

  task automatic t_reload_write();
    logic [31:0] d; logic v;
    pulse_reload();
    bus_write(waddr(30), 32'h1234_5678);
    chk("R3 error on write during reload", 32'(error), 1);
    pulse_clr();
    bus_read(waddr(30), d, v);
    chk("R3 word unchanged", d, fuse_val(30));
    wait_idle();
    bus_read(waddr(10), d, v);
    chk("R2 reload restores word10", d, fuse_val(10));
  endtask

  task automatic t_out_of_range();
    logic [31:0] d; logic v;
    bus_read(waddr(NW), d, v);
    chk("R8 beyond count zero", d, 0);
    chk("R8 beyond count no error", 32'(error), 0);
    bus_read(AW'(32'h3F0), d, v);
    chk("R8 below window zero", d, 0);
    bus_write(waddr(NW), 32'hFFFF_FFFF);
    chk("R8 write beyond no error", 32'(error), 0);
    bus_read(waddr(0), d, v);
    chk("R8 no wrap to word0", d, fuse_val(0));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_reload_len();
    t_write();
    t_wr_lock();
    t_rd_lock();
    t_reload_write();
    t_out_of_range();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule